// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point datapath and owns its control/status word. Each time the datapath finishes an operation it presents a vector of cause bits. While the register's enable bit is set, the block turns those causes into sticky flag bits. Several invalid-operation causes fold into one invalid flag, and some of them also set a NaN or infinity flag.

After every accepted update, if any of the eight flags is set in the updated word, the block pulses an exception request. Alongside the pulse it latches the program counter of the instruction that caused it. Software can overwrite the whole word through a write port, and that is the only way to clear a flag.

The arithmetic itself is not part of this block. The rounding-mode bits and bit 7 are storage only, written and read by software.

Top module: `fpu_flag_acc`

## Requirements
- R1: After synchronous reset the register reads 0 (enable clear), `exc_req` is 0 and `exc_pc` is 0.
- R2: While register bit 0 (enable) is 0, `op_done` has no effect: the register does not change and no request is raised.
- R3: With enable set, a completed operation with any of `op_status` bits 0..8 set (0 signalling NaN, 1 quiet NaN, 2 inf minus inf, 3 inf divided by inf, 4 zero divided by zero, 5 inf times zero, 6 bad conversion, 7 bad compare, 8 bad square root) sets the invalid flag, bit 9.
- R4: Cause bit 0 also sets the signalling-NaN flag (bit 5), and cause bit 1 also sets the quiet-NaN flag (bit 6).
- R5: Cause bits 2 and 3 also set the infinity flag (bit 10).
- R6: The remaining causes each set one flag: overflow cause (bit 9) sets bit 3, underflow cause (bit 10) sets bit 4, divide-by-zero cause (bit 12 of the status is inexact, bit 11 is divide-by-zero) sets bit 11, and the inexact cause (bit 12) sets bit 8.
- R7: Flags are sticky. A hardware update only ORs bits in, so an operation with an all-zero status leaves the flags set.
- R8: One cycle after an accepted update, `exc_req` is 1 for exactly one cycle if any of bits 3,4,5,6,8,9,10,11 is set in the updated register. In that same cycle `exc_pc` equals the `prev_pc` presented with the operation.
- R9: A software write in the same cycle as a completed operation wins. The register takes the written value and no request follows.
- R10: A software write stores bits 11..0 of `sw_wdata`, including the rounding mode (bits 2..1) and bit 7. Bits above 11 always read 0.
- R11: `exc_pc` holds its value in every cycle in which no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_done | input | 1 | Operation-complete strobe from the datapath |
| op_status | input | 13 | Cause vector of the completed operation |
| prev_pc | input | PC_W | Address of the instruction that completed |
| sw_wr | input | 1 | Software write strobe for the register |
| sw_wdata | input | CSR_W | Software write data |
| csr_q | output | CSR_W | Current register value |
| exc_req | output | 1 | One-cycle floating-point exception request |
| exc_pc | output | PC_W | Faulting PC that goes with the request |

## Verification
The bench builds the block with CSR_W = 16 and PC_W = 24. The 16-bit register width leaves four unimplemented upper bits, so the bench can write ones into them and confirm they read back as zero. The 24-bit PC lets random addresses show that the captured fault address is the one from the triggering operation and not from a later one. A behavioural reference model runs alongside the design and is compared with it on every clock. Directed phases cover each cause bit in isolation, write-versus-update collisions, and requests driven only by flags that were already sticky. A random phase then mixes all of these.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;
   // implemented width of the control/status word
   localparam int FLAG_BITS = 12;

   // register bit positions (bits 2..1 rounding mode, bit 7 spare: storage only)
   localparam int B_EN  = 0;
   localparam int B_OVF = 3;
   localparam int B_UNF = 4;
   localparam int B_SNF = 5;
   localparam int B_QNF = 6;
   localparam int B_IXF = 8;
   localparam int B_IVF = 9;
   localparam int B_INF = 10;
   localparam int B_DZF = 11;

   // cause vector positions
   localparam int ST_W   = 13;
   localparam int S_SNAN = 0;
   localparam int S_QNAN = 1;
   localparam int S_ISI  = 2;
   localparam int S_IDI  = 3;
   localparam int S_ZDZ  = 4;
   localparam int S_IMZ  = 5;
   localparam int S_CVI  = 6;
   localparam int S_CMP  = 7;
   localparam int S_SQRT = 8;
   localparam int S_OVF  = 9;
   localparam int S_UNF  = 10;
   localparam int S_DZ   = 11;
   localparam int S_INX  = 12;

   localparam logic [ST_W-1:0] INVALID_SET =
      ST_W'((1 << S_SNAN) | (1 << S_QNAN) | (1 << S_ISI) | (1 << S_IDI) |
            (1 << S_ZDZ)  | (1 << S_IMZ)  | (1 << S_CVI) | (1 << S_CMP) |
            (1 << S_SQRT));
   localparam logic [ST_W-1:0] INF_SET = ST_W'((1 << S_ISI) | (1 << S_IDI));

   localparam logic [FLAG_BITS-1:0] FLAG_MASK =
      FLAG_BITS'((1 << B_OVF) | (1 << B_UNF) | (1 << B_SNF) | (1 << B_QNF) |
                 (1 << B_IXF) | (1 << B_IVF) | (1 << B_INF) | (1 << B_DZF));

   // flag bits that one cause bit drives
   function automatic logic [FLAG_BITS-1:0] cause_route(input int c);
      logic [FLAG_BITS-1:0] r;
      r = '0;
      if (INVALID_SET[c]) r[B_IVF] = 1'b1;
      if (INF_SET[c])     r[B_INF] = 1'b1;
      if (c == S_SNAN)    r[B_SNF] = 1'b1;
      if (c == S_QNAN)    r[B_QNF] = 1'b1;
      if (c == S_OVF)     r[B_OVF] = 1'b1;
      if (c == S_UNF)     r[B_UNF] = 1'b1;
      if (c == S_DZ)      r[B_DZF] = 1'b1;
      if (c == S_INX)     r[B_IXF] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/fpu_cause_fold.sv
module fpu_cause_fold
   import fpu_flag_pkg::*;
(
   input  logic [ST_W-1:0]      status,
   output logic [FLAG_BITS-1:0] raise
);
   logic [ST_W-1:0][FLAG_BITS-1:0] contrib;

   // one routing term per cause bit
   for (genvar g = 0; g < ST_W; g++) begin : g_cause
      assign contrib[g] = status[g] ? cause_route(g) : '0;
   end

   always_comb begin
      raise = '0;
      for (int i = 0; i < ST_W; i++) raise = raise | contrib[i];
   end
endmodule

// File: rtl/fpu_flag_reg.sv
module fpu_flag_reg
   import fpu_flag_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [FLAG_BITS-1:0] wdata,
   input  logic                 upd,
   input  logic [FLAG_BITS-1:0] raise,
   output logic [FLAG_BITS-1:0] word_q,
   output logic [FLAG_BITS-1:0] word_nxt,
   output logic                 fire
);
   // hardware update only when enabled and software is not writing
   assign fire     = upd && word_q[B_EN] && !wr_en;
   assign word_nxt = word_q | raise;

   always_ff @(posedge clk) begin
      if (rst)        word_q <= '0;
      else if (wr_en) word_q <= wdata;
      else if (fire)  word_q <= word_nxt;
   end
endmodule

// File: rtl/fpu_exc_gen.sv
module fpu_exc_gen
   import fpu_flag_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fire,
   input  logic [FLAG_BITS-1:0] word_nxt,
   input  logic [PC_W-1:0]      pc_in,
   output logic                 req,
   output logic [PC_W-1:0]      pc_out
);
   logic raise_req;
   assign raise_req = fire && |(word_nxt & FLAG_MASK);

   always_ff @(posedge clk) begin
      if (rst) begin
         req    <= 1'b0;
         pc_out <= '0;
      end else begin
         req <= raise_req;
         if (raise_req) pc_out <= pc_in;
      end
   end
endmodule

// File: rtl/fpu_flag_acc.sv
module fpu_flag_acc
   import fpu_flag_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int CSR_W = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 op_done,
   input  logic [ST_W-1:0]      op_status,
   input  logic [PC_W-1:0]      prev_pc,
   input  logic                 sw_wr,
   input  logic [CSR_W-1:0]     sw_wdata,
   output logic [CSR_W-1:0]     csr_q,
   output logic                 exc_req,
   output logic [PC_W-1:0]      exc_pc
);
   localparam int PAD_W = CSR_W - FLAG_BITS;

   if (CSR_W < FLAG_BITS) begin : g_bad_csr_w
      $error("CSR_W must be at least the implemented flag width");
   end
   if (PC_W < 1) begin : g_bad_pc_w
      $error("PC_W must be positive");
   end

   logic [FLAG_BITS-1:0] raise;
   logic [FLAG_BITS-1:0] word_q;
   logic [FLAG_BITS-1:0] word_nxt;
   logic                 fire;

   fpu_cause_fold u_fold (
      .status (op_status),
      .raise  (raise)
   );

   fpu_flag_reg u_reg (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (sw_wr),
      .wdata    (sw_wdata[FLAG_BITS-1:0]),
      .upd      (op_done),
      .raise    (raise),
      .word_q   (word_q),
      .word_nxt (word_nxt),
      .fire     (fire)
   );

   fpu_exc_gen #(.PC_W(PC_W)) u_exc (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire),
      .word_nxt (word_nxt),
      .pc_in    (prev_pc),
      .req      (exc_req),
      .pc_out   (exc_pc)
   );

   // bits above the implemented word read zero
   if (PAD_W > 0) begin : g_pad
      assign csr_q = {{PAD_W{1'b0}}, word_q};
   end else begin : g_exact
      assign csr_q = word_q;
   end
endmodule

// File: rtl/fpu_flag_acc_chk.sv
module fpu_flag_acc_chk
   import fpu_flag_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int CSR_W = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             op_done,
   input logic [ST_W-1:0]  op_status,
   input logic [PC_W-1:0]  prev_pc,
   input logic             sw_wr,
   input logic [CSR_W-1:0] sw_wdata,
   input logic [CSR_W-1:0] csr_q,
   input logic             exc_req,
   input logic [PC_W-1:0]  exc_pc
);
   localparam logic [CSR_W-1:0] IMPL  = CSR_W'({FLAG_BITS{1'b1}});
   localparam logic [CSR_W-1:0] FLAGS = CSR_W'(FLAG_MASK);

   p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr && !csr_q[B_EN]) |=> ($stable(csr_q) && !exc_req));

   p_invalid_r3: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr && op_done && csr_q[B_EN] && |(op_status & INVALID_SET))
      |=> csr_q[B_IVF]);

   p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      !sw_wr |=> ((csr_q & $past(csr_q) & FLAGS) == ($past(csr_q) & FLAGS)));

   p_req_cause_r8: assert property (@(posedge clk) disable iff (rst)
      exc_req |-> ($past(op_done) && !$past(sw_wr) && $past(csr_q[B_EN])
                   && (csr_q & FLAGS) != '0 && exc_pc == $past(prev_pc)));

   p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
      sw_wr |=> (csr_q == ($past(sw_wdata) & IMPL) && !exc_req));

   p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (csr_q & ~IMPL) == '0);

   p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !exc_req |-> $stable(exc_pc));
endmodule

bind fpu_flag_acc fpu_flag_acc_chk #(.PC_W(PC_W), .CSR_W(CSR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op_done   (op_done),
   .op_status (op_status),
   .prev_pc   (prev_pc),
   .sw_wr     (sw_wr),
   .sw_wdata  (sw_wdata),
   .csr_q     (csr_q),
   .exc_req   (exc_req),
   .exc_pc    (exc_pc)
);

// File: tb/sim_fpu_flag_acc.sv
`timescale 1ns/1ps
module sim_fpu_flag_acc;
   localparam int PW = 24;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          op_done = 1'b0;
   logic [12:0]   op_status = '0;
   logic [PW-1:0] prev_pc = '0;
   logic          sw_wr = 1'b0;
   logic [CW-1:0] sw_wdata = '0;
   logic [CW-1:0] csr_q;
   logic          exc_req;
   logic [PW-1:0] exc_pc;

   int    checks = 0;
   int    errors = 0;
   string phase  = "R1";
   bit    done   = 0;

   // reference model state
   logic [CW-1:0] m_csr = '0;
   logic          m_req = 1'b0;
   logic [PW-1:0] m_pc  = '0;

   always #2 clk = ~clk;

   fpu_flag_acc #(.PC_W(PW), .CSR_W(CW)) u0 (
      .clk(clk), .rst(rst), .op_done(op_done), .op_status(op_status),
      .prev_pc(prev_pc), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .csr_q(csr_q), .exc_req(exc_req), .exc_pc(exc_pc));

   always @(posedge clk) begin
      logic [CW-1:0] f;
      if (rst) begin
         m_csr = '0; m_req = 1'b0; m_pc = '0;
      end else if (sw_wr) begin
         m_csr = sw_wdata & 16'h0FFF;
         m_req = 1'b0;
      end else if (op_done && m_csr[0]) begin
         f = '0;
         if (|op_status[8:0])             f[9]  = 1'b1;
         if (op_status[0])                f[5]  = 1'b1;
         if (op_status[1])                f[6]  = 1'b1;
         if (op_status[2] | op_status[3]) f[10] = 1'b1;
         if (op_status[9])                f[3]  = 1'b1;
         if (op_status[10])               f[4]  = 1'b1;
         if (op_status[11])               f[11] = 1'b1;
         if (op_status[12])               f[8]  = 1'b1;
         m_csr = m_csr | f;
         m_req = |(m_csr & 16'h0F78);
         if (m_req) m_pc = prev_pc;
      end else begin
         m_req = 1'b0;
      end
   end

   task automatic check(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // advance one clock and compare against the model 1 ns after the edge
   task automatic tick();
      @(posedge clk);
      #1;
      check(phase, "csr_q", csr_q, m_csr);
      check(phase, "exc_req", exc_req, m_req);
      check(phase, "exc_pc", exc_pc, m_pc);
   endtask

   task automatic sw_write(logic [CW-1:0] v);
      sw_wr = 1'b1; sw_wdata = v;
      tick();
      sw_wr = 1'b0;
   endtask

   task automatic do_op(logic [12:0] st, logic [PW-1:0] pc);
      op_done = 1'b1; op_status = st; prev_pc = pc;
      tick();
      op_done = 1'b0; op_status = '0;
   endtask

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      phase = "R1";
      tick();
      check("R1", "reset csr", csr_q, 0);
      check("R1", "reset req", exc_req, 0);
      check("R1", "reset pc", exc_pc, 0);

      phase = "R2";
      do_op(13'h1FFF, 24'h000100);
      tick();
      check("R2", "disabled csr", csr_q, 0);
      check("R2", "disabled req", exc_req, 0);

      phase = "R10";
      sw_write(16'hF005);
      check("R10", "write masks upper", csr_q, 16'h0005);
      sw_write(16'h0083);
      check("R10", "rmode and bit7 kept", csr_q, 16'h0083);

      for (int c = 0; c < 9; c++) begin
         phase = (c < 2) ? "R4" : ((c < 4) ? "R5" : "R3");
         sw_write(16'h0001);
         do_op(13'(1 << c), 24'(32'h1000 + c));
         check("R3", "invalid flag", csr_q[9], 1);
         check("R8", "request on cause", exc_req, 1);
      end
      sw_write(16'h0001);
      do_op(13'h0001, 24'h0000AA);
      check("R4", "snan word", csr_q, 16'h0221);
      sw_write(16'h0001);
      do_op(13'h0004, 24'h0000AB);
      check("R5", "isi word", csr_q, 16'h0601);

      phase = "R6";
      for (int c = 9; c < 13; c++) begin
         sw_write(16'h0001);
         do_op(13'(1 << c), 24'(32'h2000 + c));
      end
      check("R6", "inexact word", csr_q, 16'h0101);

      phase = "R7";
      sw_write(16'h0001);
      do_op(13'h0200, 24'h00ABCD);
      do_op(13'h0000, 24'h00BEEF);
      check("R7", "sticky ovf", csr_q, 16'h0009);
      check("R8", "request from sticky", exc_req, 1);
      check("R8", "faulting pc", exc_pc, 24'h00BEEF);

      phase = "R11";
      repeat (3) tick();
      check("R11", "pc held", exc_pc, 24'h00BEEF);
      check("R8", "single pulse", exc_req, 0);

      phase = "R9";
      sw_wr = 1'b1; sw_wdata = 16'h0001;
      op_done = 1'b1; op_status = 13'h0200; prev_pc = 24'h00CAFE;
      tick();
      sw_wr = 1'b0; op_done = 1'b0; op_status = '0;
      check("R9", "write wins", csr_q, 16'h0001);
      check("R9", "no request", exc_req, 0);
      do_op(13'h0000, 24'h00D00D);
      check("R8", "no flags no request", exc_req, 0);

      phase = "R8";
      for (int i = 0; i < 400; i++) begin
         sw_wr     = ($urandom_range(0, 9) == 0);
         sw_wdata  = 16'($urandom) | 16'(($urandom_range(0, 3) != 0) ? 1 : 0);
         op_done   = ($urandom_range(0, 1) == 1);
         op_status = ($urandom_range(0, 2) == 0) ? 13'(1 << $urandom_range(0, 12)) :
                     (($urandom_range(0, 1) == 1) ? 13'($urandom) : 13'h0);
         prev_pc   = 24'($urandom);
         tick();
      end
      sw_wr = 1'b0; op_done = 1'b0;
      tick();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule